// File: doc/BRIEF.md
# Visibility Query Tracking Unit

This unit follows visibility (occlusion) queries for the front end of a graphics command processor. It decodes the first word of query packets, which either open or close a query. While a query is open, a one-cycle pulse from the rasterizer marks that a sample was visible, and the unit remembers this in an internal flag. When the query closes, the flag is written into a 64-entry table of per-ID visibility bits. Software reads that table as two 32-bit status words.

The unit also decodes the leading word of each draw packet. A draw may be tied to a query ID. If it is, the draw goes ahead only when the stored bit for that ID says the query was visible. A control register sits on a small register port. When this register has both its enable bit and its discard bit set, the unit raises a pixel-kill level. The rasterizer then tests the geometry for visibility but writes no pixels. The unit also sends start and end event strobes to the rest of the pipe.

Top module: `vizq_tracker`

## Requirements
- R1: After a synchronous active-high reset, both status words and the control register read as zero. The draw_go, draw_drop, evt_start, evt_end and pix_kill outputs are all low.
- R2: A query word carries its ID in bits [5:0] and its operation in bit 8 (0 = begin, 1 = end). In the cycle after the word is presented, a begin gives a one-cycle pulse on evt_start and an end gives a one-cycle pulse on evt_end.
- R3: A begin clears the internal visible flag and opens a query. While a query is open, a sample_visible pulse sets the flag, and the flag stays set until the next begin. A pulse while no query is open is ignored.
- R4: An end writes the result into the status bit of its ID. The result is the flag, or a sample_visible pulse arriving in the same cycle. A zero result clears the bit, and all other bits keep their values. An end with no open query commits the current flag, which is 0 after reset or after a query that saw nothing.
- R5: Status word 0 is at register address 1 and holds IDs 0..31 at bit position ID. Status word 1 is at address 2 and holds IDs 32..63 at bit position ID-32. A set bit means visible.
- R6: The control register is at address 0 and keeps nine bits: enable at bit 0, selected query ID at bits 6:1, discard at bit 7 and a detail flag at bit 8. It reads back with the upper bits as zero. The detail flag has no effect on any output.
- R7: pix_kill is high from the cycle after a control write, exactly when the written value has both bit 0 and bit 7 set.
- R8: A draw word with bit 8 set uses the query whose ID is in bits [5:0]. In the next cycle the unit gives a one-cycle draw_go pulse if that ID's status bit is 1, and a draw_drop pulse otherwise. The status bit is taken as it stood before any end in the same cycle.
- R9: A draw word of zero, or any draw word with bit 8 clear, gives a draw_go pulse in the next cycle and never a draw_drop.
- R10: In the cycle after reg_rd, reg_rdata holds the addressed register, and between reads it holds its last value. Address 3 reads zero. Writes to addresses other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qpkt_valid | input | 1 | Query packet first word present |
| qpkt_word | input | 32 | Query packet first word |
| draw_valid | input | 1 | Draw packet leading word present |
| draw_word | input | 32 | Draw packet leading query word |
| sample_visible | input | 1 | One-cycle pulse from the rasterizer: a sample passed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| evt_start | output | 1 | Query start event strobe |
| evt_end | output | 1 | Query end event strobe |
| draw_go | output | 1 | Draw accepted pulse |
| draw_drop | output | 1 | Draw rejected pulse |
| pix_kill | output | 1 | Discard pixels after the visibility test |

## Verification
Some rules are checked on every cycle by the assertions. A begin always leaves the flag clear. A flag with no open query never moves. Every end lands its result in the addressed status bit. Each draw turns into exactly the go or drop pulse that its flag and the stored bit call for. The pixel-kill level follows a control write. Read-modify behaviour across a whole query can only be shown by the bench's scenarios: an end leaving the other 63 bits alone, an end with no begin committing zero, the detail flag being inert, and a draw in the same cycle as an end seeing the old bit. The bench compares every output against its model each clock.

// File: rtl/vizq_pkg.sv
package vizq_pkg;
  // Packet word decode positions
  localparam int unsigned OP_BIT    = 8;
  localparam int unsigned USE_BIT   = 8;
  // Control register layout
  localparam int unsigned CTRL_W    = 9;
  localparam int unsigned CTL_ENA   = 0;
  localparam int unsigned CTL_KILL  = 7;
  localparam int unsigned CTL_DET   = 8;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_STAT0 = 2'd1,
    RA_STAT1 = 2'd2,
    RA_SPARE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/vizq_status_bank.sv
module vizq_status_bank #(
  parameter int unsigned ID_W   = 6,
  parameter int unsigned WORD_W = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ID_W-1:0]                    wr_id,
  input  logic                               wr_val,
  input  logic [ID_W-1:0]                    rd_id,
  output logic                               rd_bit,
  output logic [(1<<ID_W)-1:0]               words
);
  localparam int unsigned NUM_IDS = 1 << ID_W;
  localparam int unsigned NWORDS  = NUM_IDS / WORD_W;
  localparam int unsigned BIT_W   = $clog2(WORD_W);
  localparam int unsigned SEL_W   = ID_W - BIT_W;

  logic [WORD_W-1:0] word_q [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[w] <= '0;
      end else if (wr_en && (wr_id[ID_W-1:BIT_W] == SEL_W'(w))) begin
        word_q[w][wr_id[BIT_W-1:0]] <= wr_val;
      end
    end
    assign words[w*WORD_W +: WORD_W] = word_q[w];
  end

  assign rd_bit = words[rd_id];

  // An end commit lands its value in the addressed bit.
  assert_commit_lands_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (words[$past(wr_id)] == $past(wr_val)));
endmodule

// File: rtl/vizq_query_ctl.sv
module vizq_query_ctl #(
  parameter int unsigned ID_W   = 6,
  parameter int unsigned PKT_W  = 32,
  parameter int unsigned OP_BIT = vizq_pkg::OP_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_valid,
  input  logic [PKT_W-1:0] q_word,
  input  logic             sample_vis,
  output logic             evt_start,
  output logic             evt_end,
  output logic             commit_en,
  output logic [ID_W-1:0]  commit_id,
  output logic             commit_val
);
  logic flag_q, active_q;
  logic do_begin, do_end;

  assign do_begin   = q_valid && !q_word[OP_BIT];
  assign do_end     = q_valid &&  q_word[OP_BIT];
  assign commit_en  = do_end;
  assign commit_id  = q_word[ID_W-1:0];
  assign commit_val = flag_q || (active_q && sample_vis);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      active_q  <= 1'b0;
      evt_start <= 1'b0;
      evt_end   <= 1'b0;
    end else begin
      evt_start <= do_begin;
      evt_end   <= do_end;
      if (do_begin) begin
        flag_q   <= 1'b0;
        active_q <= 1'b1;
      end else begin
        if (active_q && sample_vis) flag_q <= 1'b1;
        if (do_end) active_q <= 1'b0;
      end
    end
  end

  assert_begin_clears_R3: assert property (@(posedge clk) disable iff (rst)
    do_begin |=> !flag_q);

  assert_idle_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (!q_valid && !active_q) |=> $stable(flag_q));

  assert_end_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    do_end |=> (evt_end && !evt_start));
endmodule

// File: rtl/vizq_draw_gate.sv
module vizq_draw_gate #(
  parameter int unsigned ID_W    = 6,
  parameter int unsigned USE_BIT = vizq_pkg::USE_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [USE_BIT:0]  d_field,
  input  logic              stat_bit,
  output logic [ID_W-1:0]   look_id,
  output logic              draw_go,
  output logic              draw_drop
);
  logic use_q;

  assign look_id = d_field[ID_W-1:0];
  assign use_q   = d_field[USE_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      draw_go   <= 1'b0;
      draw_drop <= 1'b0;
    end else begin
      draw_go   <= d_valid && (!use_q || stat_bit);
      draw_drop <= d_valid && use_q && !stat_bit;
    end
  end

  assert_gated_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (d_valid && use_q && !stat_bit) |=> (draw_drop && !draw_go));

  assert_plain_go_R9: assert property (@(posedge clk) disable iff (rst)
    (d_valid && !use_q) |=> (draw_go && !draw_drop));
endmodule

// File: rtl/vizq_tracker.sv
module vizq_tracker #(
  parameter int unsigned ID_W   = 6,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PKT_W  = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qpkt_valid,
  input  logic [PKT_W-1:0]  qpkt_word,
  input  logic              draw_valid,
  input  logic [PKT_W-1:0]  draw_word,
  input  logic              sample_visible,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              evt_start,
  output logic              evt_end,
  output logic              draw_go,
  output logic              draw_drop,
  output logic              pix_kill
);
  import vizq_pkg::*;

  localparam int unsigned NUM_IDS = 1 << ID_W;
  localparam int unsigned NWORDS  = NUM_IDS / WORD_W;

  logic                  commit_en, commit_val, stat_bit;
  logic [ID_W-1:0]       commit_id, look_id;
  logic [NUM_IDS-1:0]    stat_words;
  logic [CTRL_W-1:0]     ctrl_q;
  logic [WORD_W-1:0]     rd_mux;
  logic                  ctrl_wr;

  vizq_query_ctl #(.ID_W(ID_W), .PKT_W(PKT_W)) u_qctl (
    .clk(clk), .rst(rst),
    .q_valid(qpkt_valid), .q_word(qpkt_word), .sample_vis(sample_visible),
    .evt_start(evt_start), .evt_end(evt_end),
    .commit_en(commit_en), .commit_id(commit_id), .commit_val(commit_val)
  );

  vizq_status_bank #(.ID_W(ID_W), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(commit_en), .wr_id(commit_id), .wr_val(commit_val),
    .rd_id(look_id), .rd_bit(stat_bit), .words(stat_words)
  );

  vizq_draw_gate #(.ID_W(ID_W)) u_gate (
    .clk(clk), .rst(rst),
    .d_valid(draw_valid), .d_field(draw_word[USE_BIT:0]), .stat_bit(stat_bit),
    .look_id(look_id), .draw_go(draw_go), .draw_drop(draw_drop)
  );

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(RA_CTRL));

  // Control register and the pixel-kill level it drives
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      pix_kill <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q   <= reg_wdata[CTRL_W-1:0];
      pix_kill <= reg_wdata[CTL_ENA] && reg_wdata[CTL_KILL];
    end
  end

  // Read mux: control at 0, status words from 1 upward, zero elsewhere
  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(RA_CTRL)) rd_mux = WORD_W'(ctrl_q);
    for (int k = 0; k < NWORDS; k++) begin
      if (reg_addr == ADDR_W'(k + 1)) rd_mux = stat_words[k*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assert_pixkill_follow_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (pix_kill == ($past(reg_wdata[CTL_ENA]) && $past(reg_wdata[CTL_KILL]))));

  assert_ones_kill_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && (reg_wdata == '1)) |=> pix_kill);

  assert_spare_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(RA_SPARE)) |=> (reg_rdata == '0));

  assert_zero_word_begin_R2: assert property (@(posedge clk) disable iff (rst)
    (qpkt_valid && qpkt_word == '0) |=> evt_start);

  assert_zero_draw_go_R9: assert property (@(posedge clk) disable iff (rst)
    (draw_valid && draw_word == '0) |=> draw_go);
endmodule

// File: tb/vizq_tracker_bench.sv
module vizq_tracker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        qpkt_valid = 1'b0, draw_valid = 1'b0, sample_visible = 1'b0;
  logic [31:0] qpkt_word = '0, draw_word = '0, reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_rdata;
  logic        evt_start, evt_end, draw_go, draw_drop, pix_kill;

  always #5 clk = ~clk;

  vizq_tracker u_vizq_tracker (
    .clk(clk), .rst(rst),
    .qpkt_valid(qpkt_valid), .qpkt_word(qpkt_word),
    .draw_valid(draw_valid), .draw_word(draw_word),
    .sample_visible(sample_visible),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_start(evt_start), .evt_end(evt_end),
    .draw_go(draw_go), .draw_drop(draw_drop), .pix_kill(pix_kill)
  );

  // Behavioural reference state
  bit          m_stat [64];
  logic [8:0]  m_ctrl = '0;
  bit          m_flag = 0, m_active = 0;
  logic [31:0] e_rdata = '0;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] stat_word(int base);
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) v[i] = m_stat[base + i];
    return v;
  endfunction

  // One clock: predict, advance, compare every output
  task automatic cyc(string rtag);
    logic e_start, e_end, e_go, e_drop, e_pk, cval;
    logic [5:0] did;
    e_start = qpkt_valid && !qpkt_word[8];
    e_end   = qpkt_valid &&  qpkt_word[8];
    did     = draw_word[5:0];
    e_go    = draw_valid && (!draw_word[8] || m_stat[did]);
    e_drop  = draw_valid && draw_word[8] && !m_stat[did];
    if (reg_rd) begin
      case (reg_addr)
        2'd0:    e_rdata = {23'b0, m_ctrl};
        2'd1:    e_rdata = stat_word(0);
        2'd2:    e_rdata = stat_word(32);
        default: e_rdata = '0;
      endcase
    end
    cval = m_flag || (m_active && sample_visible);
    if (e_start) begin
      m_flag = 0; m_active = 1;
    end else begin
      if (m_active && sample_visible) m_flag = 1;
      if (e_end) begin
        m_stat[qpkt_word[5:0]] = cval;
        m_active = 0;
      end
    end
    if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata[8:0];
    e_pk = m_ctrl[0] && m_ctrl[7];
    @(posedge clk); #2;
    chk("R2 evt_start", 32'(evt_start), 32'(e_start));
    chk("R2 evt_end",   32'(evt_end),   32'(e_end));
    chk(draw_word[8] ? "R8 draw_go" : "R9 draw_go", 32'(draw_go), 32'(e_go));
    chk(draw_word[8] ? "R8 draw_drop" : "R9 draw_drop", 32'(draw_drop), 32'(e_drop));
    chk("R7 pix_kill", 32'(pix_kill), 32'(e_pk));
    chk(rtag, reg_rdata, e_rdata);
    qpkt_valid = 0; draw_valid = 0; sample_visible = 0;
    reg_wr = 0; reg_rd = 0; draw_word = '0;
  endtask

  task automatic qpkt(int id, bit fin);
    qpkt_valid = 1; qpkt_word = {23'b0, fin, 2'b0, 6'(id)};
  endtask
  task automatic draw(int id, bit use_q);
    draw_valid = 1; draw_word = {23'b0, use_q, 2'b0, 6'(id)};
  endtask
  task automatic rd(int a);
    reg_rd = 1; reg_addr = 2'(a);
  endtask
  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1; reg_addr = 2'(a); reg_wdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_stat[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // R1: outputs after reset
    chk("R1 outputs", {27'b0, evt_start, evt_end, draw_go, draw_drop, pix_kill}, 32'h0);
    rd(0); cyc("R1 ctrl");
    rd(1); cyc("R1 stat0");
    rd(2); cyc("R1 stat1");

    // R4: end with no begin commits not-visible
    qpkt(5, 1); cyc("R4");
    rd(1); cyc("R4 stat0");
    // R3/R5: visible query on ID 5 and on ID 40
    qpkt(5, 0); cyc("R3");
    sample_visible = 1; cyc("R3");
    cyc("R3");
    qpkt(5, 1); cyc("R3");
    rd(1); cyc("R5 stat0 id5");
    qpkt(40, 0); cyc("R3");
    sample_visible = 1; cyc("R3");
    qpkt(40, 1); cyc("R3");
    rd(2); cyc("R5 stat1 id40");
    // R4: revisit ID 5 with nothing visible clears only that bit
    qpkt(5, 0); cyc("R4");
    cyc("R4");
    qpkt(5, 1); cyc("R4");
    rd(1); cyc("R4 stat0 cleared");
    rd(2); cyc("R4 stat1 kept");
    // R3: pulse with no open query is ignored
    sample_visible = 1; cyc("R3");
    qpkt(7, 1); cyc("R3");
    rd(1); cyc("R3 idle pulse ignored");
    // R4: sample in the same cycle as end counts
    qpkt(9, 0); cyc("R4");
    qpkt(9, 1); sample_visible = 1; cyc("R4");
    rd(1); cyc("R4 same-cycle sample");

    // R8/R9: draw gating
    draw(40, 1); cyc("R8");
    draw(5, 1);  cyc("R8");
    draw_valid = 1; draw_word = '0; cyc("R9");
    draw(5, 0); cyc("R9");
    // R8: draw in same cycle as end sees old bit
    qpkt(12, 0); cyc("R8");
    sample_visible = 1; cyc("R8");
    qpkt(12, 1); draw(12, 1); cyc("R8");
    draw(12, 1); cyc("R8");

    // R6/R7: control register
    wr(0, 32'h181); cyc("R6");
    rd(0); cyc("R6 readback");
    wr(0, 32'h081); cyc("R6 detail inert");
    wr(0, 32'h101); cyc("R7");
    wr(0, 32'hFFFF_FFFF); cyc("R7");
    rd(0); cyc("R6 upper zero");
    wr(0, 32'h080); cyc("R7");
    // R10: status writes ignored, spare reads zero, rdata holds
    wr(1, 32'h0); cyc("R10");
    rd(1); cyc("R10 stat0 unchanged");
    cyc("R10 hold");
    rd(3); cyc("R10 spare");

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 15));
      if (r < 3) qpkt(int'($urandom_range(0, 63)), r[0]);
      if (r[1]) sample_visible = 1;
      if ($urandom_range(0, 2) == 0) draw(int'($urandom_range(0, 63)), $urandom_range(0, 1) == 1);
      if (r == 9) wr(int'($urandom_range(0, 3)), $urandom);
      else if (r > 10) rd(int'($urandom_range(0, 3)));
      cyc("R10 mixed");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule